// File: doc/BRIEF.md
# Dual-Width ROM Read Port

A synchronous read port for a small mask-style ROM that can present its contents either as 16-bit words or as 8-bit bytes. A width-select input picks the organisation. In word form the full word reaches the data bus. In byte form an extra low address bit picks the lower or the upper half of the addressed word, and that half is placed on lanes 7..0.

Two active-low controls gate the bus. Chip enable high puts the port in standby. Output enable high, with chip enable low, disables the outputs. A signature request reads out fixed manufacturer and device identifier codes in place of array data. That request is only valid while every address bit above bit 0 is zero.

The port gives a per-bit drive mask beside the data so that a surrounding model can build tri-state pins. Data, mask and the error flag are all registered: the inputs sampled at one rising clock edge decide the outputs that hold until the next edge.

Top module: `dwrom_port`

## Requirements
- R1: With width select high, chip enable and output enable low and no signature request, the outputs after the next rising edge are: data_o equal to image(addr_i) and data_oe_o = 16'hFFFF. The image is image(a) = ((a * 16'h9E37) mod 2^16) XOR SEED, with SEED defaulting to 16'h5A3C.
- R2: With width select low and the extra address bit low (other controls as in R1), the outputs are data_o = {8'h00, image(addr_i)[7:0]} and data_oe_o = 16'h00FF.
- R3: With width select low and the extra address bit high, the outputs are data_o = {8'h00, image(addr_i)[15:8]} and data_oe_o = 16'h00FF.
- R4: The extra address bit has no effect in word form: data_o and data_oe_o are the same for both of its values.
- R5: With chip enable high, data_oe_o is 0, data_o is 0 and id_err_o is 0 after the next edge, whatever the levels of output enable, width select and signature request.
- R6: With chip enable low and output enable high, data_oe_o and data_o are 0 after the next edge.
- R7: With a signature request, chip enable and output enable low, and addr_i[ADDR_W-1:1] zero, the outputs are: lanes 7..0 carry 8'h20 when addr_i[0] is 0 and 8'hB2 when addr_i[0] is 1, data_oe_o = 16'h00FF, and data_o[15:8] = 0. This holds in either width.
- R8: With a signature request, chip enable low and any of addr_i[ADDR_W-1:1] set, id_err_o is 1 and data_oe_o and data_o are 0 after the next edge, whatever the output-enable level. In every other case id_err_o is 0.
- R9: Every bit of data_o whose data_oe_o bit is 0 reads 0.
- R10: While rst_ni is low, data_o, data_oe_o and id_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_sel_i | input | 1 | 1: word organisation, 0: byte organisation |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Word address |
| lsb_i | input | 1 | Half-word selector, used in byte form only |
| id_req_i | input | 1 | Signature readout request |
| data_o | output | 16 | Registered read data |
| data_oe_o | output | 16 | Per-bit drive enable for data_o |
| id_err_o | output | 1 | Signature request made with a non-zero upper address |

## Verification
The bench builds the port with its defaults: ADDR_W = 6, which gives 64 words, and SEED = 16'h5A3C. At that size every address can be swept in word form and in both byte halves, so every image entry is compared on every lane. The six address bits also leave five upper bits that can spoil a signature request, so each of them is set on its own to raise the error flag. Randomly mixed controls then test standby, output disable and mode changes from one cycle to the next against a bench model.

// File: rtl/dwrom_pkg.sv
package dwrom_pkg;
  localparam int unsigned DATA_W = 16;
  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = 8'hB2;

  typedef enum logic [2:0] {
    M_OFF, M_WORD, M_BYTE_LO, M_BYTE_HI, M_ID, M_ERR
  } mode_e;

  function automatic logic [DATA_W-1:0] image_word(input logic [31:0] a,
                                                   input logic [DATA_W-1:0] seed);
    logic [DATA_W-1:0] p;
    p = a[DATA_W-1:0] * 16'h9E37;
    return p ^ seed;
  endfunction
endpackage

// File: rtl/dwrom_rom.sv
module dwrom_rom
  import dwrom_pkg::*;
#(
  parameter int unsigned      ADDR_W = 6,
  parameter logic [DATA_W-1:0] SEED  = 16'h5A3C
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] tbl [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_row
    assign tbl[g] = image_word(32'(g), SEED);
  end

  assign word_o = tbl[addr_i];
endmodule

// File: rtl/dwrom_decode.sv
module dwrom_decode
  import dwrom_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              wide_sel_i,
  input  logic              lsb_i,
  input  logic              id_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mode_e             mode_o
);
  logic upper_set;
  assign upper_set = |addr_i[ADDR_W-1:1];

  always_comb begin
    mode_o = M_OFF;
    if (!ce_ni) begin
      if (id_req_i) begin
        // bad signature address flags even with outputs disabled
        if (upper_set)   mode_o = M_ERR;
        else if (!oe_ni) mode_o = M_ID;
      end else if (!oe_ni) begin
        if (wide_sel_i)  mode_o = M_WORD;
        else if (lsb_i)  mode_o = M_BYTE_HI;
        else             mode_o = M_BYTE_LO;
      end
    end
  end
endmodule

// File: rtl/dwrom_lane.sv
module dwrom_lane
  import dwrom_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              id_sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] oe_o,
  output logic              err_o
);
  localparam int unsigned HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [DATA_W-1:0] data_d, oe_d;
  logic              err_d;

  always_comb begin
    data_d = '0;
    oe_d   = '0;
    err_d  = 1'b0;
    unique case (mode_i)
      M_WORD: begin
        data_d = word_i;
        oe_d   = '1;
      end
      M_BYTE_LO: begin
        data_d = {{HALF{1'b0}}, word_i[HALF-1:0]};
        oe_d   = LOW_MASK;
      end
      M_BYTE_HI: begin
        data_d = {{HALF{1'b0}}, word_i[DATA_W-1:HALF]};
        oe_d   = LOW_MASK;
      end
      M_ID: begin
        data_d = {{HALF{1'b0}}, (id_sel_i ? DEV_CODE : MFR_CODE)};
        oe_d   = LOW_MASK;
      end
      M_ERR:   err_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      oe_o   <= '0;
      err_o  <= 1'b0;
    end else begin
      data_o <= data_d;
      oe_o   <= oe_d;
      err_o  <= err_d;
    end
  end
endmodule

// File: rtl/dwrom_port.sv
module dwrom_port
  import dwrom_pkg::*;
#(
  parameter int unsigned       ADDR_W = 6,
  parameter logic [DATA_W-1:0] SEED   = 16'h5A3C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_sel_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lsb_i,
  input  logic              id_req_i,
  output logic [15:0]       data_o,
  output logic [15:0]       data_oe_o,
  output logic              id_err_o
);
  mode_e             mode;
  logic [DATA_W-1:0] word;

  dwrom_rom #(.ADDR_W(ADDR_W), .SEED(SEED)) u_rom (
    .addr_i (addr_i),
    .word_o (word)
  );

  dwrom_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .wide_sel_i (wide_sel_i),
    .lsb_i      (lsb_i),
    .id_req_i   (id_req_i),
    .addr_i     (addr_i),
    .mode_o     (mode)
  );

  dwrom_lane u_lane (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .word_i   (word),
    .id_sel_i (addr_i[0]),
    .data_o   (data_o),
    .oe_o     (data_oe_o),
    .err_o    (id_err_o)
  );
endmodule

// File: rtl/dwrom_port_chk.sv
module dwrom_port_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wide_sel_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              lsb_i,
  input logic              id_req_i,
  input logic [15:0]       data_o,
  input logic [15:0]       data_oe_o,
  input logic              id_err_o
);
  logic sel_ok;
  assign sel_ok = !ce_ni && !oe_ni && !id_req_i;

  // R1
  word_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ok && wide_sel_i |=> data_oe_o == 16'hFFFF);

  // R2
  byte_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ok && !wide_sel_i |=> data_oe_o == 16'h00FF && data_o[15:8] == 8'h00);

  // R5
  standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> data_oe_o == '0 && !id_err_o);

  // R6
  out_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni && oe_ni |=> data_oe_o == '0);

  // R7
  id_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni && !oe_ni && id_req_i && addr_i[ADDR_W-1:1] == '0
    |=> data_o == {8'h00, ($past(addr_i[0]) ? 8'hB2 : 8'h20)} && data_oe_o == 16'h00FF);

  // R8
  id_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_ni && id_req_i && |addr_i[ADDR_W-1:1] |=> id_err_o && data_oe_o == '0);

  // R8
  err_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_req_i && !ce_ni) |=> !id_err_o);
endmodule

bind dwrom_port dwrom_port_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dwrom_port_bench.sv
`timescale 1ns/1ps
module dwrom_port_bench;
  localparam int unsigned AW   = 6;
  localparam logic [15:0] SEED = 16'h5A3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide = 1'b1, ce_n = 1'b1, oe_n = 1'b1, lsb = 1'b0, idr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] data, doe;
  logic err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dwrom_port #(.ADDR_W(AW), .SEED(SEED)) u_dwrom_port (
    .clk_i(clk), .rst_ni(rst_n), .wide_sel_i(wide), .ce_ni(ce_n), .oe_ni(oe_n),
    .addr_i(addr), .lsb_i(lsb), .id_req_i(idr),
    .data_o(data), .data_oe_o(doe), .id_err_o(err)
  );

  function automatic logic [15:0] img(input int a);
    logic [15:0] p;
    p = 16'(a) * 16'h9E37;
    return p ^ SEED;
  endfunction

  // expected {data, oe, err} and the requirement tag for the case
  function automatic logic [32:0] model(input logic w, c, o, l, r, input logic [AW-1:0] a,
                                        output string tag);
    logic [15:0] d, m;
    logic e;
    d = '0; m = '0; e = 1'b0; tag = "R5";
    if (!c) begin
      if (r) begin
        if (a[AW-1:1] != '0) begin e = 1'b1; tag = "R8"; end
        else if (o) tag = "R6";
        else begin d = {8'h00, (a[0] ? 8'hB2 : 8'h20)}; m = 16'h00FF; tag = "R7"; end
      end else if (o) tag = "R6";
      else if (w) begin d = img(int'(a)); m = 16'hFFFF; tag = "R1"; end
      else if (l) begin d = {8'h00, img(int'(a))[15:8]}; m = 16'h00FF; tag = "R3"; end
      else begin d = {8'h00, img(int'(a))[7:0]}; m = 16'h00FF; tag = "R2"; end
    end
    return {d, m, e};
  endfunction

  task automatic cmp(input string tag, input logic [32:0] exp);
    checks++;
    if ({data, doe, err} !== exp) begin
      errors++;
      $display("FAIL %s: got data=%h oe=%h err=%b exp data=%h oe=%h err=%b",
               tag, data, doe, err, exp[32:17], exp[16:1], exp[0]);
    end
    checks++;
    if ((data & ~doe) !== 16'h0) begin
      errors++;
      $display("FAIL R9: got undriven bits %h exp 0000", data & ~doe);
    end
  endtask

  task automatic step(input logic w, c, o, l, r, input logic [AW-1:0] a);
    string tag;
    logic [32:0] exp;
    wide = w; ce_n = c; oe_n = o; lsb = l; idr = r; addr = a;
    exp = model(w, c, o, l, r, a, tag);
    @(posedge clk); #1;
    cmp(tag, exp);
  endtask

  initial begin
    logic [32:0] ref_v;
    string t;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    cmp("R10", 33'h0);
    rst_n = 1'b1;

    // exhaustive sweeps: word, byte low, byte high
    for (int a = 0; a < (1 << AW); a++) step(1, 0, 0, 0, 0, AW'(a));
    for (int a = 0; a < (1 << AW); a++) step(0, 0, 0, 0, 0, AW'(a));
    for (int a = 0; a < (1 << AW); a++) step(0, 0, 0, 1, 0, AW'(a));

    // R4: extra bit ignored in word form
    for (int a = 0; a < 8; a++) begin
      step(1, 0, 0, 0, 0, AW'(a * 7));
      ref_v = {data, doe, err};
      step(1, 0, 0, 1, 0, AW'(a * 7));
      checks++;
      if ({data, doe, err} !== ref_v) begin
        errors++;
        $display("FAIL R4: got %h exp %h", {data, doe, err}, ref_v);
      end
    end

    // R7 codes in both widths
    step(1, 0, 0, 0, 1, AW'(0));
    step(1, 0, 0, 0, 1, AW'(1));
    step(0, 0, 0, 1, 1, AW'(0));
    step(0, 0, 0, 0, 1, AW'(1));
    // R8 each upper bit alone, with oe either level
    for (int b = 1; b < AW; b++) begin
      step(1, 0, 0, 0, 1, AW'(1 << b));
      step(0, 0, 1, 0, 1, AW'((1 << b) | 1));
    end
    // R5 standby with all else active; R6 disable
    step(1, 1, 0, 0, 1, AW'(2));
    step(0, 1, 0, 1, 0, AW'(5));
    step(1, 0, 1, 0, 0, AW'(9));
    step(0, 0, 1, 1, 1, AW'(0));

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic r;
      logic [AW-1:0] a;
      r = ($urandom % 4) == 0;
      a = AW'($urandom);
      if (r && ($urandom % 2)) a = AW'(a[0]);
      step(1'($urandom), (($urandom % 5) == 0), (($urandom % 5) == 0),
           1'($urandom), r, a);
    end
    t = "";
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule